// File: doc/BRIEF.md
# Taken-Only Branch Target Buffer

This block gives the fetch stage a next-address guess for the current program counter. It holds a small fully associative table. Each entry pairs the address of a branch instruction with the address that branch last jumped to. When the fetch address matches a valid entry, the block predicts taken and offers the stored target as the next fetch address. With no match it predicts not taken and offers the sequential address, four bytes on. The lookup is combinational, so a redirect can apply in the same cycle that the address is presented.

Only branches believed taken are stored, so whether an entry is present acts as a one-bit history. The execute stage reports each resolved branch on an update port with the branch address, its outcome and its target. A taken branch that misses is allocated. The new entry goes into the lowest-numbered free slot, or into a round-robin victim when the table is full. A taken branch that hits has its target rewritten. A not-taken branch that hits loses its entry. All table changes land at the next rising clock edge.

Top module: `taken_target_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup predicts not taken.
- R2: On a lookup miss, `pred_taken` is 0 and `pred_next_pc` equals `fetch_pc + 4`, modulo 2^ADDR_W.
- R3: On a lookup hit, `pred_taken` is 1 and `pred_next_pc` equals the target stored for that branch, in the same cycle as the lookup.
- R4: A resolved taken branch whose address is not in the table is allocated. From the next cycle its lookups hit with the reported target.
- R5: A resolved not-taken branch whose address is in the table has its entry invalidated. From the next cycle its lookups miss.
- R6: A resolved taken branch whose address is already in the table keeps its entry and has its stored target replaced by the newly reported target.
- R7: A resolved not-taken branch whose address is not in the table leaves the table unchanged.
- R8: An allocation while at least one entry is invalid uses the lowest-numbered invalid entry and does not move the round-robin pointer.
- R9: An allocation into a full table replaces the entry at the round-robin pointer. The pointer starts at entry 0 after reset and then advances by one, wrapping after the last entry.
- R10: When a lookup and an update address the same entry in one cycle, the lookup returns the contents from before the update. The update is visible from the next cycle.
- R11: With `upd_valid` low, the update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_taken | output | 1 | 1 when `fetch_pc` hits a valid entry |
| pred_next_pc | output | ADDR_W | Stored target on a hit, `fetch_pc + 4` on a miss |
| upd_valid | input | 1 | A resolved branch is being reported this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | ADDR_W | Resolved target address |

## Verification
Assertions check the following on every cycle:
- no address ever matches more than one entry;
- a miss always yields the sequential address;
- an allocation fills the chosen slot with the reported address;
- an allocation into a table with room always lands on a slot that was free;
- the round-robin pointer moves only on a replacement into a full table;
- a not-taken hit clears its slot;
- a not-taken miss and an idle update port leave the valid bits unchanged.

Some behaviour shows only through directed scenarios at the ports. The exact replacement order under eviction (which earlier branches survive after mixed refills and invalidations) is one such case. Target refresh for a branch whose destination changes is another. A third is the old-contents result when a lookup and an update meet on the same entry in one cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    TC_IDLE    = 2'd0,
    TC_ALLOC   = 2'd1,
    TC_REFRESH = 2'd2,
    TC_DROP    = 2'd3
  } tc_action_e;

  // Decide what a resolution report does to the table.
  function automatic tc_action_e tc_classify(input logic valid_i,
                                             input logic taken_i,
                                             input logic hit_i);
    if (!valid_i)            return TC_IDLE;
    if (taken_i && hit_i)    return TC_REFRESH;
    if (taken_i)             return TC_ALLOC;
    if (hit_i)               return TC_DROP;
    return TC_IDLE;
  endfunction

endpackage

// File: rtl/tc_match.sv
module tc_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ADDR_W-1:0]  tag_i [ENTRIES],
  input  logic [ADDR_W-1:0]  key_i,
  output logic [ENTRIES-1:0] match_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tc_victim.sv
module tc_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   rr_ptr_i,
  output logic               full_o,
  output logic [IDX_W-1:0]   victim_o
);

  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  // Lowest-numbered invalid slot: scan from the top down so slot 0 wins.
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign full_o   = !free_found;
  assign victim_o = free_found ? free_idx : rr_ptr_i;

endmodule

// File: rtl/tc_store.sv
module tc_store
  import tc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tc_action_e         act_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               full_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [ADDR_W-1:0]  target_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ADDR_W-1:0]  tag_o [ENTRIES],
  output logic [ADDR_W-1:0]  tgt_o [ENTRIES],
  output logic [IDX_W-1:0]   rr_ptr_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] rr_advance(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= '0;
      rr_ptr_o <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_o[i] <= '0;
        tgt_o[i] <= '0;
      end
    end else begin
      unique case (act_i)
        TC_ALLOC: begin
          valid_o[idx_i] <= 1'b1;
          tag_o[idx_i]   <= pc_i;
          tgt_o[idx_i]   <= target_i;
          if (full_i) rr_ptr_o <= rr_advance(rr_ptr_o);
        end
        TC_REFRESH: tgt_o[idx_i]   <= target_i;
        TC_DROP:    valid_o[idx_i] <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/taken_target_cache.sv
module taken_target_cache
  import tc_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int INSTR_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  function automatic logic [ADDR_W-1:0] seq_next(input logic [ADDR_W-1:0] pc);
    return pc + STEP;
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr_q;

  // Named internal events for the assertions.
  logic [ENTRIES-1:0] look_match, upd_match;
  logic               look_hit, upd_hit, tbl_full;
  logic [IDX_W-1:0]   look_idx, upd_hit_idx, victim_idx, wr_idx;
  tc_action_e         upd_act;
  logic               ev_alloc, ev_drop;

  tc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) look_i (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(fetch_pc),
    .match_o(look_match), .hit_o(look_hit), .idx_o(look_idx)
  );

  tc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) resolve_i (
    .valid_i(valid_q), .tag_i(tag_q), .key_i(upd_pc),
    .match_o(upd_match), .hit_o(upd_hit), .idx_o(upd_hit_idx)
  );

  tc_victim #(.ENTRIES(ENTRIES)) victim_i (
    .valid_i(valid_q), .rr_ptr_i(rr_ptr_q),
    .full_o(tbl_full), .victim_o(victim_idx)
  );

  assign upd_act  = tc_classify(upd_valid, upd_taken, upd_hit);
  assign wr_idx   = upd_hit ? upd_hit_idx : victim_idx;
  assign ev_alloc = (upd_act == TC_ALLOC);
  assign ev_drop  = (upd_act == TC_DROP);

  tc_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .act_i(upd_act), .idx_i(wr_idx),
    .full_i(tbl_full), .pc_i(upd_pc), .target_i(upd_target),
    .valid_o(valid_q), .tag_o(tag_q), .tgt_o(tgt_q), .rr_ptr_o(rr_ptr_q)
  );

  // Lookup reads registered state only, so same-cycle updates are unseen (R10).
  assign pred_taken   = look_hit;
  assign pred_next_pc = look_hit ? tgt_q[look_idx] : seq_next(fetch_pc);

  // R3: a branch address never occupies two entries.
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match) && $onehot0(upd_match));

  // R2: a miss yields the sequential address.
  a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> pred_next_pc == fetch_pc + STEP);

  // R4: an allocated slot holds the reported branch and target next cycle.
  a_r4_alloc_fills: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(upd_pc)
                 && tgt_q[$past(wr_idx)] == $past(upd_target));

  // R5: a not-taken hit clears its slot.
  a_r5_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> !valid_q[$past(upd_hit_idx)]);

  // R7 / R11: a not-taken miss or an idle port leaves the valid bits alone.
  a_r7_quiet_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || (!upd_taken && !upd_hit)) |=> valid_q == $past(valid_q));

  // R8: with room in the table, allocation lands on a free slot.
  a_r8_uses_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_alloc && !tbl_full) |-> !valid_q[wr_idx]);

  // R9: the pointer moves only on a replacement into a full table.
  a_r9_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_alloc && tbl_full) |=> $stable(rr_ptr_q));

endmodule

// File: tb/taken_target_cache_tb_top.sv
`timescale 1ns/1ps
module taken_target_cache_tb_top;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_taken;
  logic [AW-1:0] pred_next_pc;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_pc = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_target = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  taken_target_cache dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target)
  );

  function automatic logic [AW-1:0] br(input int i);
    return 32'h0000_1000 + 32'(i * 16);
  endfunction
  function automatic logic [AW-1:0] dst(input int i);
    return 32'h0004_0000 + 32'(i * 256);
  endfunction

  task automatic check(input string req, input logic [AW:0] act, input logic [AW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present a fetch address and compare the prediction; expectations are (taken, next).
  task automatic probe(input string req, input logic [AW-1:0] pc,
                       input logic exp_t, input logic [AW-1:0] exp_n);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    check(req, {pred_taken, pred_next_pc}, {exp_t, exp_n});
  endtask

  task automatic hit_at(input string req, input int i, input logic [AW-1:0] t);
    probe(req, br(i), 1'b1, t);
  endtask
  task automatic miss_at(input string req, input int i);
    probe(req, br(i), 1'b0, br(i) + 32'd4);
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic tk, input logic [AW-1:0] t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = t;
    @(posedge clk);
    #1 upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 3; i++) miss_at("R1 empty after reset", i);
    probe("R2 wrap of sequential address", 32'hFFFF_FFFC, 1'b0, 32'h0);
  endtask

  task automatic t_alloc_hit();
    do_reset();
    resolve(br(1), 1'b1, dst(1));
    hit_at("R4 allocated on taken miss", 1, dst(1));
    hit_at("R3 hit returns stored target", 1, dst(1));
    miss_at("R2 other address still misses", 2);
  endtask

  task automatic t_refresh_drop();
    resolve(br(1), 1'b1, dst(9));
    hit_at("R6 target overwritten", 1, dst(9));
    resolve(br(2), 1'b0, dst(2));
    miss_at("R7 not-taken miss not allocated", 2);
    hit_at("R7 existing entry untouched", 1, dst(9));
    resolve(br(1), 1'b0, dst(1));
    miss_at("R5 not-taken hit invalidated", 1);
  endtask

  task automatic t_idle_port();
    resolve(br(3), 1'b1, dst(3));
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = br(3); upd_taken = 1'b0; upd_target = dst(7);
    @(posedge clk);
    @(negedge clk);
    upd_pc = br(4); upd_taken = 1'b1;
    @(posedge clk);
    hit_at("R11 idle port kept entry", 3, dst(3));
    miss_at("R11 idle port allocated nothing", 4);
  endtask

  task automatic t_same_cycle();
    do_reset();
    resolve(br(5), 1'b1, dst(5));
    @(negedge clk);
    fetch_pc = br(5);
    upd_valid = 1'b1; upd_pc = br(5); upd_taken = 1'b0; upd_target = '0;
    #1;
    check("R10 lookup sees old contents", {pred_taken, pred_next_pc}, {1'b1, dst(5)});
    @(posedge clk);
    #1 upd_valid = 1'b0;
    check("R10 update visible next cycle", {pred_taken, pred_next_pc}, {1'b0, br(5) + 32'd4});
  endtask

  task automatic t_replacement();
    do_reset();
    for (int i = 0; i < 8; i++) resolve(br(i), 1'b1, dst(i));
    for (int i = 0; i < 8; i++) hit_at("R8 fill uses free slots", i, dst(i));
    resolve(br(8), 1'b1, dst(8));     // full: slot 0 replaced, pointer to 1
    miss_at("R9 first victim is slot 0", 0);
    hit_at("R9 new entry present", 8, dst(8));
    resolve(br(9), 1'b1, dst(9));     // slot 1 replaced, pointer to 2
    miss_at("R9 second victim is slot 1", 1);
    resolve(br(4), 1'b0, dst(4));     // slot 4 freed
    resolve(br(10), 1'b1, dst(10));   // goes to slot 4, pointer stays 2
    hit_at("R8 free slot reused", 10, dst(10));
    hit_at("R8 slot 2 survived refill", 2, dst(2));
    resolve(br(11), 1'b1, dst(11));   // full: slot 2 replaced
    miss_at("R8 pointer unmoved by free-slot fill", 2);
    hit_at("R9 slot 3 survives", 3, dst(3));
    hit_at("R9 newest entry present", 11, dst(11));
    hit_at("R9 entry in slot 7 kept", 7, dst(7));
  endtask

  initial begin
    t_reset();
    t_alloc_hit();
    t_refresh_drop();
    t_idle_port();
    t_same_cycle();
    t_replacement();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule